// File: doc/BRIEF.md
# PCI Target Read Prefetch Buffer with Start Hold

This block is a dual-clock first-in first-out buffer between an application and the target read path of a PCI interface. The application writes words in its own clock domain through an active-low write enable and watches active-low full and almost-full flags. The PCI side runs on the bus clock. It takes words from a show-ahead output with a pop strobe and sees an active-low empty flag.

A start gate holds back the PCI-side burst so the application can pre-fill the buffer. The PCI side raises a start request. The gate asserts a go indication once the application's hold input is low, or once the bus side sees the buffer full, whichever comes first. Go stays high until the PCI side signals the end of the transaction.

Read and write pointers are Gray coded. Each pointer crosses into the other domain through two flops per bit. A write attempted while full is dropped and sets a sticky overflow bit.

Top module: `pci_rd_prefetch_fifo`

## Requirements
- R1: While reset is asserted and right after it, full_no=1, afull_no=1, empty_no=0, go_o=0 and ovf_o=0.
- R2: A word on wr_data_i is stored on each rising wclk_i edge while wr_en_ni is low and the buffer is not full. Words come out on rd_data_o in write order, and each pop_i pulse moves to the next word.
- R3: full_no is low while the write side counts DEPTH entries. A write while full is ignored, so stored words are unchanged and no extra word appears. It also sets ovf_o, which stays high until reset.
- R4: afull_no is low while four or fewer entries are free (count >= DEPTH-4). With DEPTH=16 it is high at 11 entries and low at 12.
- R5: empty_no is low while the read side sees no stored word. A pop while empty is ignored, and the next word written is the next word read.
- R6: With hold_i low, a start_req_i pulse makes go_o high after the next rclk_i edge.
- R7: While hold_i is high and the buffer is not seen full, go_o stays low after a start request. It rises one rclk_i edge after hold_i falls.
- R8: With hold_i still high, a pending start request raises go_o once the read side sees DEPTH stored entries.
- R9: go_o stays high until end_i is sampled high, and then returns low. A later hold release with no new start request leaves go_o low.
- R10: hold_i, once raised, stays high for at least two rclk_i cycles. This is an input rule that the design checks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk_i | input | 1 | Application (write) clock |
| rclk_i | input | 1 | PCI bus (read) clock |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| wr_en_ni | input | 1 | Active-low write enable |
| wr_data_i | input | DW | Write data |
| full_no | output | 1 | Active-low full, write domain |
| afull_no | output | 1 | Active-low almost full, write domain |
| ovf_o | output | 1 | Sticky write-while-full flag |
| hold_i | input | 1 | Burst start hold, read domain |
| start_req_i | input | 1 | Burst start request pulse |
| end_i | input | 1 | End of transaction pulse |
| go_o | output | 1 | Burst may proceed |
| pop_i | input | 1 | Take the current head word |
| rd_data_o | output | DW | Head word (show-ahead) |
| empty_no | output | 1 | Active-low empty, read domain |

## Verification
The two release causes of the start gate can meet: hold is still asserted at the moment the buffer fills. The bench keeps hold high, issues a start request and fills the buffer in two halves. Go must stay low after the first half and rise after the second, with hold never released. A later hold release must then leave go low once end has been seen.

// File: rtl/pfifo_pkg.sv
package pfifo_pkg;
  typedef enum logic [1:0] {
    GATE_IDLE = 2'd0,
    GATE_WAIT = 2'd1,
    GATE_GO   = 2'd2
  } gate_state_e;
endpackage

// File: rtl/pfifo_sync.sv
module pfifo_sync #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/pfifo_wr_ctrl.sv
module pfifo_wr_ctrl #(
  parameter int AW         = 4,
  parameter int AFULL_FREE = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_ni,
  input  logic [AW:0] rgray_sync_i,
  output logic [AW:0] wbin_o,
  output logic [AW:0] wgray_o,
  output logic        push_o,
  output logic        full_no,
  output logic        afull_no,
  output logic        ovf_o
);
  localparam int PW = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0] FULL_LVL  = PW'(DEPTH);
  localparam logic [AW:0] AFULL_LVL = PW'(DEPTH - AFULL_FREE);

  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [AW:0] wbin_q, wgray_q, wbin_d, count;
  logic        full, ovf_q;

  assign count  = wbin_q - g2b(rgray_sync_i);
  assign full   = (count == FULL_LVL);
  assign push_o = !wr_en_ni && !full;
  assign wbin_d = wbin_q + PW'(push_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      ovf_q   <= 1'b0;
    end else begin
      wbin_q  <= wbin_d;
      wgray_q <= wbin_d ^ (wbin_d >> 1);
      if (!wr_en_ni && full) ovf_q <= 1'b1;
    end
  end

  assign wbin_o   = wbin_q;
  assign wgray_o  = wgray_q;
  assign full_no  = !full;
  assign afull_no = !(count >= AFULL_LVL);
  assign ovf_o    = ovf_q;

  a_r3_no_write_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!full_no && !wr_en_ni) |=> $stable(wbin_q));
  a_r3_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);
  a_r4_afull_covers_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !full_no |-> !afull_no);
endmodule

// File: rtl/pfifo_rd_ctrl.sv
module pfifo_rd_ctrl #(
  parameter int AW = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        pop_i,
  input  logic [AW:0] wgray_sync_i,
  output logic [AW:0] rbin_o,
  output logic [AW:0] rgray_o,
  output logic        empty_no,
  output logic        full_seen_o
);
  localparam int PW = AW + 1;
  localparam logic [AW:0] FULL_LVL = PW'(1 << AW);

  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [AW:0] rbin_q, rgray_q, rbin_d, count;
  logic        empty, take;

  assign count  = g2b(wgray_sync_i) - rbin_q;
  assign empty  = (count == '0);
  assign take   = pop_i && !empty;
  assign rbin_d = rbin_q + PW'(take);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q  <= '0;
      rgray_q <= '0;
    end else begin
      rbin_q  <= rbin_d;
      rgray_q <= rbin_d ^ (rbin_d >> 1);
    end
  end

  assign rbin_o      = rbin_q;
  assign rgray_o     = rgray_q;
  assign empty_no    = !empty;
  assign full_seen_o = (count == FULL_LVL);

  a_r5_no_pop_when_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!empty_no && pop_i) |=> $stable(rbin_q));
endmodule

// File: rtl/pfifo_start_gate.sv
module pfifo_start_gate
  import pfifo_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic full_seen_i,
  input  logic start_req_i,
  input  logic end_i,
  output logic go_o
);
  gate_state_e state_q, state_d;
  logic        release_ok;

  assign release_ok = !hold_i || full_seen_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      GATE_IDLE: if (start_req_i) state_d = release_ok ? GATE_GO : GATE_WAIT;
      GATE_WAIT: if (release_ok)  state_d = GATE_GO;
      GATE_GO:   if (end_i)       state_d = GATE_IDLE;
      default:                    state_d = GATE_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= GATE_IDLE;
    else         state_q <= state_d;
  end

  assign go_o = (state_q == GATE_GO);

  a_r7_held_stays_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && !full_seen_i && !go_o) |=> !go_o);
  a_r9_go_until_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_o && !end_i) |=> go_o);
  a_r9_end_drops_go: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_o && end_i) |=> !go_o);
  a_r10_hold_min_two: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold_i) |=> hold_i);
endmodule

// File: rtl/pci_rd_prefetch_fifo.sv
module pci_rd_prefetch_fifo #(
  parameter int DW         = 32,
  parameter int DEPTH      = 16,
  parameter int AFULL_FREE = 4
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          wr_en_ni,
  input  logic [DW-1:0] wr_data_i,
  output logic          full_no,
  output logic          afull_no,
  output logic          ovf_o,
  input  logic          hold_i,
  input  logic          start_req_i,
  input  logic          end_i,
  output logic          go_o,
  input  logic          pop_i,
  output logic [DW-1:0] rd_data_o,
  output logic          empty_no
);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW:0]   wbin, wgray, rbin, rgray, wgray_sync, rgray_sync;
  logic          push, full_seen;

  pfifo_wr_ctrl #(.AW(AW), .AFULL_FREE(AFULL_FREE)) u_wr (
    .clk_i(wclk_i), .rst_ni(rst_ni), .wr_en_ni(wr_en_ni),
    .rgray_sync_i(rgray_sync), .wbin_o(wbin), .wgray_o(wgray),
    .push_o(push), .full_no(full_no), .afull_no(afull_no), .ovf_o(ovf_o)
  );

  pfifo_rd_ctrl #(.AW(AW)) u_rd (
    .clk_i(rclk_i), .rst_ni(rst_ni), .pop_i(pop_i),
    .wgray_sync_i(wgray_sync), .rbin_o(rbin), .rgray_o(rgray),
    .empty_no(empty_no), .full_seen_o(full_seen)
  );

  pfifo_sync #(.W(AW+1)) u_sync_w2r (
    .clk_i(rclk_i), .rst_ni(rst_ni), .d_i(wgray), .q_o(wgray_sync)
  );

  pfifo_sync #(.W(AW+1)) u_sync_r2w (
    .clk_i(wclk_i), .rst_ni(rst_ni), .d_i(rgray), .q_o(rgray_sync)
  );

  pfifo_start_gate u_gate (
    .clk_i(rclk_i), .rst_ni(rst_ni), .hold_i(hold_i), .full_seen_i(full_seen),
    .start_req_i(start_req_i), .end_i(end_i), .go_o(go_o)
  );

  always_ff @(posedge wclk_i) begin
    if (push) mem[wbin[AW-1:0]] <= wr_data_i;
  end

  assign rd_data_o = mem[rbin[AW-1:0]];
endmodule

// File: tb/pci_rd_prefetch_fifo_test.sv
module pci_rd_prefetch_fifo_test;
  localparam int DW = 32;
  localparam int DEPTH = 16;

  logic wclk = 0, rclk = 0, rst_n = 0;
  logic wr_en_n = 1, hold = 0, start_req = 0, end_t = 0, pop = 0;
  logic [DW-1:0] wr_data = '0;
  logic full_n, afull_n, ovf, go, empty_n;
  logic [DW-1:0] rd_data;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #2.5 rclk = ~rclk;
  always #3   wclk = ~wclk;

  pci_rd_prefetch_fifo #(.DW(DW), .DEPTH(DEPTH), .AFULL_FREE(4)) uut (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_n), .wr_en_ni(wr_en_n),
    .wr_data_i(wr_data), .full_no(full_n), .afull_no(afull_n), .ovf_o(ovf),
    .hold_i(hold), .start_req_i(start_req), .end_i(end_t), .go_o(go),
    .pop_i(pop), .rd_data_o(rd_data), .empty_no(empty_n)
  );

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_burst(int n, logic [DW-1:0] base);
    @(negedge wclk);
    for (int i = 0; i < n; i++) begin
      wr_en_n = 0; wr_data = base + DW'(i);
      @(negedge wclk);
    end
    wr_en_n = 1;
  endtask

  task automatic drain(int n, logic [DW-1:0] base, string req);
    repeat (6) @(negedge rclk);
    for (int i = 0; i < n; i++) begin
      chk(req, rd_data, base + DW'(i));
      pop = 1;
      @(negedge rclk);
      pop = 0;
      @(negedge rclk);
    end
    repeat (6) @(negedge rclk);
  endtask

  task automatic pulse_r(ref logic s);
    s = 1; @(negedge rclk); s = 0;
  endtask

  task automatic t_reset;
    chk("R1 full_no", full_n, 1); chk("R1 afull_no", afull_n, 1);
    chk("R1 empty_no", empty_n, 0); chk("R1 go_o", go, 0); chk("R1 ovf_o", ovf, 0);
  endtask

  task automatic t_fill_overflow;
    wr_burst(11, 32'h100);
    chk("R4 afull at 11", afull_n, 1);
    wr_burst(1, 32'h10B);
    chk("R4 afull at 12", afull_n, 0);
    chk("R3 not full at 12", full_n, 1);
    wr_burst(4, 32'h10C);
    chk("R3 full at 16", full_n, 0);
    wr_burst(1, 32'hDEAD);
    chk("R3 ovf set", ovf, 1);
    chk("R3 still full", full_n, 0);
    repeat (3) @(negedge rclk);
    chk("R5 not empty", empty_n, 1);
    drain(DEPTH, 32'h100, "R2 order");
    chk("R3 no extra word", empty_n, 0);
    repeat (4) @(negedge wclk);
    chk("R3 ovf sticky", ovf, 1);
    chk("R3 full cleared", full_n, 1);
  endtask

  task automatic t_pop_empty;
    @(negedge rclk);
    pop = 1; @(negedge rclk); pop = 0;
    wr_burst(1, 32'h5A5A);
    repeat (6) @(negedge rclk);
    chk("R5 pop on empty ignored", rd_data, 32'h5A5A);
    drain(1, 32'h5A5A, "R2 single");
    chk("R5 empty again", empty_n, 0);
  endtask

  task automatic t_go_free;
    @(negedge rclk);
    pulse_r(start_req);
    chk("R6 go immediate", go, 1);
    repeat (3) @(negedge rclk);
    chk("R9 go held", go, 1);
    pulse_r(end_t);
    chk("R9 go dropped", go, 0);
  endtask

  task automatic t_go_hold;
    @(negedge rclk);
    hold = 1;
    pulse_r(start_req);
    repeat (5) @(negedge rclk);
    chk("R7 held no go", go, 0);
    hold = 0;
    @(negedge rclk);
    chk("R7 go after release", go, 1);
    pulse_r(end_t);
    chk("R9 end after hold", go, 0);
  endtask

  task automatic t_go_full;
    @(negedge rclk);
    hold = 1;
    pulse_r(start_req);
    wr_burst(8, 32'h200);
    repeat (8) @(negedge rclk);
    chk("R7 half full no go", go, 0);
    wr_burst(8, 32'h208);
    repeat (8) @(negedge rclk);
    chk("R8 full releases go", go, 1);
    chk("R8 hold still high", hold, 1);
    pulse_r(end_t);
    chk("R9 end drops go", go, 0);
    hold = 0;
    repeat (3) @(negedge rclk);
    chk("R9 no go without request", go, 0);
    drain(DEPTH, 32'h200, "R2 second fill");
  endtask

  initial begin
    repeat (4) @(negedge rclk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge rclk);
    t_reset();
    t_fill_overflow();
    t_pop_empty();
    t_go_free();
    t_go_hold();
    t_go_full();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge rclk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end
endmodule